// File: doc/BRIEF.md
# Handshaked PHY Register Access Master

This block reads and writes 16-bit registers that live inside a PHY and are not reachable through the memory map. All traffic passes through one 20-bit control word that the block drives and one 17-bit status word that it samples. Every transfer is split into phases: capture of the address, capture of the data (writes only), and a final write or read strobe. Each phase uses a four-phase request/acknowledge handshake. The strobe is raised, the acknowledge must rise, the strobe is dropped, and the acknowledge must fall.

A client issues one command at a time on a simple valid/ready interface. The command gives the direction, a 16-bit PHY address and, for writes, 16-bit data. The block answers with a one-cycle done pulse. On the same cycle it shows an error flag when the PHY did not answer in time, and after a read it holds the data read. Every wait for an acknowledge level is bounded. The block samples the acknowledge a limited number of times, with a fixed spacing given in clock cycles. If the expected level never shows up, the transfer is abandoned and the control word is parked at zero.

Top module: `phy_reg_master`

## Requirements
- R1: Control word layout: bits [15:0] carry the address or data, bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. At most one strobe is high at a time. The write and read strobes are always driven with bits [15:0] at zero. In the status word, bit 16 is the acknowledge and bits [15:0] are read data.
- R2: Address phase: the address is driven with no strobe for one cycle. Then bit 16 is added and the block waits for ack=1. Then the address is driven alone again and the block waits for ack=0.
- R3: Write phase, after the address phase: the data is driven alone for one cycle, then with bit 17 (wait for ack=1), then alone again (wait for ack=0). Next comes bit 18 alone (wait for ack=1), then the data alone (wait for ack=0). The control word then returns to zero.
- R4: Read phase, after the address phase: bit 19 is driven alone and the block waits for ack=1. It then captures status bits [15:0] into the read-data output and drives the control word to zero, then waits for ack=0. The read-data output changes only on such a capture.
- R5: Within a wait, the first acknowledge sample is taken in the first cycle of the phase. Later samples follow every POLL_GAP cycles, up to POLL_LIMIT samples in all. A phase whose acknowledge is first seen at sample s (counting from 0) lasts 1+s*POLL_GAP cycles. From the accepting clock edge, a write therefore takes 3+6 such phase times to its done pulse and a read takes 2+4.
- R6: If a wait reaches its last sample without the expected level, the block raises done with error and drives the control word to zero. It returns to idle, and the next command completes normally. A first-phase timeout gives done 3+9*POLL_GAP cycles after acceptance.
- R7: cmd_ready is high only while idle, and the control word is zero then. A command is accepted when cmd_valid and cmd_ready are both high. Commands presented while busy are ignored and leave the PHY registers untouched.
- R8: rsp_done is a single-cycle pulse. rsp_error is high only together with rsp_done, and it is low on a successful transfer.
- R9: The expected acknowledge level seen exactly on the last permitted sample counts as success, not timeout.
- R10: After reset the control word is zero, cmd_ready is high, rsp_done and rsp_error are low, and rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Data for a write |
| cmd_ready | output | 1 | Idle and able to accept a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Timeout flag, valid with rsp_done |
| rsp_rdata | output | 16 | Data from the last successful read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY (acknowledge and read data) |

## Verification
The two events that can coincide are the successful match of the acknowledge and the expiry of the sample budget. Both are decided on the final permitted sample of a wait. The bench provokes this with a responder whose acknowledge latency is swept. One latency makes the answer land exactly on the tenth sample, and the next latency makes it land one cycle after the window. The first case must finish without error and with the arithmetic phase length. The second must end in a timeout whose done pulse arrives at the computed cycle, with the control word back at zero.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;

    localparam int FIELD_W  = 16;
    localparam int STROBE_N = 4;
    localparam int CTRL_W   = FIELD_W + STROBE_N;
    localparam int STAT_W   = FIELD_W + 1;

    // strobe vector order follows the control word bit positions above FIELD_W
    localparam logic [STROBE_N-1:0] STB_NONE  = 4'b0000;
    localparam logic [STROBE_N-1:0] STB_CAP_A = 4'b0001;
    localparam logic [STROBE_N-1:0] STB_CAP_D = 4'b0010;
    localparam logic [STROBE_N-1:0] STB_WR    = 4'b0100;
    localparam logic [STROBE_N-1:0] STB_RD    = 4'b1000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_SET,
        ST_A_CAP,
        ST_A_REL,
        ST_W_SET,
        ST_W_CAP,
        ST_W_REL,
        ST_W_STB,
        ST_W_END,
        ST_R_STB,
        ST_R_END
    } step_e;

    typedef struct packed {
        step_e               step;
        logic                wr;
        logic [FIELD_W-1:0]  addr;
        logic [FIELD_W-1:0]  wdata;
        logic [CTRL_W-1:0]   ctrl;
        logic [FIELD_W-1:0]  rdata;
        logic                done;
        logic                err;
    } seq_state_t;

    function automatic logic [CTRL_W-1:0] make_word(input logic [FIELD_W-1:0] field,
                                                    input logic [STROBE_N-1:0] stb);
        return {stb, field};
    endfunction

    function automatic logic is_wait(input step_e s);
        return (s == ST_A_CAP) || (s == ST_A_REL) || (s == ST_W_CAP) ||
               (s == ST_W_REL) || (s == ST_W_STB) || (s == ST_W_END) ||
               (s == ST_R_STB) || (s == ST_R_END);
    endfunction

    function automatic logic wants_high(input step_e s);
        return (s == ST_A_CAP) || (s == ST_W_CAP) || (s == ST_W_STB) ||
               (s == ST_R_STB);
    endfunction

endpackage

// File: rtl/phyacc_poller.sv
module phyacc_poller #(
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    input  logic want_level,
    output logic hit,
    output logic expire
);
    localparam int GAP_W  = (POLL_GAP  > 1) ? $clog2(POLL_GAP + 1)   : 1;
    localparam int SAMP_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
    localparam logic [GAP_W-1:0]  GAP_RELOAD = GAP_W'(POLL_GAP - 1);
    localparam logic [SAMP_W-1:0] LAST_SAMP  = SAMP_W'(POLL_LIMIT - 1);

    logic [GAP_W-1:0]  gap_d,  gap_q;
    logic [SAMP_W-1:0] samp_d, samp_q;
    logic              tick;
    logic              match;

    always_comb begin
        tick   = (gap_q == '0);
        match  = (ack == want_level);
        hit    = active && tick && match;
        expire = active && tick && !match && (samp_q == LAST_SAMP);
        gap_d  = gap_q;
        samp_d = samp_q;
        if (!active || hit || expire) begin
            gap_d  = '0;
            samp_d = '0;
        end else if (tick) begin
            gap_d  = GAP_RELOAD;
            samp_d = samp_q + 1'b1;
        end else begin
            gap_d  = gap_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            samp_q <= '0;
        end else begin
            gap_q  <= gap_d;
            samp_q <= samp_d;
        end
    end

endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
    import phyacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [FIELD_W-1:0] cmd_addr,
    input  logic [FIELD_W-1:0] cmd_wdata,
    input  logic [FIELD_W-1:0] stat_data,
    input  logic               hit,
    input  logic               expire,
    output logic               cmd_ready,
    output logic               rsp_done,
    output logic               rsp_error,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic [CTRL_W-1:0]  ctrl_word,
    output logic               wait_active,
    output logic               wait_level
);
    seq_state_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.step)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.wr    = cmd_write;
                    d.addr  = cmd_addr;
                    d.wdata = cmd_wdata;
                    d.ctrl  = make_word(cmd_addr, STB_NONE);
                    d.step  = ST_A_SET;
                end
            end
            ST_A_SET: begin
                d.ctrl = make_word(q.addr, STB_CAP_A);
                d.step = ST_A_CAP;
            end
            ST_A_CAP: if (hit) begin
                d.ctrl = make_word(q.addr, STB_NONE);
                d.step = ST_A_REL;
            end
            ST_A_REL: if (hit) begin
                if (q.wr) begin
                    d.ctrl = make_word(q.wdata, STB_NONE);
                    d.step = ST_W_SET;
                end else begin
                    d.ctrl = make_word('0, STB_RD);
                    d.step = ST_R_STB;
                end
            end
            ST_W_SET: begin
                d.ctrl = make_word(q.wdata, STB_CAP_D);
                d.step = ST_W_CAP;
            end
            ST_W_CAP: if (hit) begin
                d.ctrl = make_word(q.wdata, STB_NONE);
                d.step = ST_W_REL;
            end
            ST_W_REL: if (hit) begin
                d.ctrl = make_word('0, STB_WR);
                d.step = ST_W_STB;
            end
            ST_W_STB: if (hit) begin
                d.ctrl = make_word(q.wdata, STB_NONE);
                d.step = ST_W_END;
            end
            ST_W_END: if (hit) begin
                d.ctrl = '0;
                d.done = 1'b1;
                d.step = ST_IDLE;
            end
            ST_R_STB: if (hit) begin
                d.rdata = stat_data;
                d.ctrl  = '0;
                d.step  = ST_R_END;
            end
            ST_R_END: if (hit) begin
                d.done = 1'b1;
                d.step = ST_IDLE;
            end
            default: begin
                d.ctrl = '0;
                d.step = ST_IDLE;
            end
        endcase
        if (expire) begin
            d.ctrl = '0;
            d.done = 1'b1;
            d.err  = 1'b1;
            d.step = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{step: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.step == ST_IDLE);
    assign rsp_done    = q.done;
    assign rsp_error   = q.err;
    assign rsp_rdata   = q.rdata;
    assign ctrl_word   = q.ctrl;
    assign wait_active = is_wait(q.step);
    assign wait_level  = wants_high(q.step);

endmodule

// File: rtl/phy_reg_master.sv
module phy_reg_master
    import phyacc_pkg::*;
#(
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [FIELD_W-1:0] cmd_addr,
    input  logic [FIELD_W-1:0] cmd_wdata,
    output logic               cmd_ready,
    output logic               rsp_done,
    output logic               rsp_error,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic [CTRL_W-1:0]  phy_ctrl,
    input  logic [STAT_W-1:0]  phy_stat
);
    logic wait_active;
    logic wait_level;
    logic hit;
    logic expire;

    phyacc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .stat_data   (phy_stat[FIELD_W-1:0]),
        .hit         (hit),
        .expire      (expire),
        .cmd_ready   (cmd_ready),
        .rsp_done    (rsp_done),
        .rsp_error   (rsp_error),
        .rsp_rdata   (rsp_rdata),
        .ctrl_word   (phy_ctrl),
        .wait_active (wait_active),
        .wait_level  (wait_level)
    );

    phyacc_poller #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (wait_active),
        .ack        (phy_stat[FIELD_W]),
        .want_level (wait_level),
        .hit        (hit),
        .expire     (expire)
    );

endmodule

// File: rtl/phy_reg_master_chk.sv
module phy_reg_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_done,
    input logic        rsp_error,
    input logic [15:0] rsp_rdata,
    input logic [19:0] phy_ctrl
);
    // R1: at most one strobe, and write/read strobes carry an empty field
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[19:16]));
    a_r1_strobe_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctrl[18] || phy_ctrl[19]) |-> (phy_ctrl[15:0] == 16'h0));
    // R2: address-capture strobe rises on top of an already presented address
    a_r2_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctrl[16]) |-> ($past(phy_ctrl[15:0]) == phy_ctrl[15:0]));
    // R3: data-capture strobe rises on top of already presented data
    a_r3_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctrl[17]) |-> ($past(phy_ctrl[15:0]) == phy_ctrl[15:0]));
    // R4: read data moves only right after the read strobe was out
    a_r4_rdata_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> $past(phy_ctrl[19]));
    // R7: idle means a parked control word; acceptance makes the block busy
    a_r7_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (phy_ctrl == 20'h0));
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid) |=> !cmd_ready);
    // R8: single-cycle done, error only with done
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> rsp_done);
endmodule

bind phy_reg_master phy_reg_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_done  (rsp_done),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata),
    .phy_ctrl  (phy_ctrl)
);

// File: tb/tb_phy_reg_master.sv
`timescale 1ns/1ps
module tb_phy_reg_master;
    localparam int LIMIT = 10;
    localparam int GAP   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_ready;
    logic        rsp_done;
    logic        rsp_error;
    logic [15:0] rsp_rdata;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    always #10 clk = ~clk;

    phy_reg_master #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // ---------------- responder model of the PHY side ----------------
    int          mode = 0;   // 0 normal, 1 ack stuck low, 2 ack stuck high
    int          lat  = 0;
    logic [31:0] hist;
    logic        ack_r;
    logic [15:0] sdata;
    logic [2:0]  r_addr;
    logic [15:0] r_data;
    logic [15:0] mem [8];
    logic [19:0] last_ctrl;
    logic [19:0] clog [4096];
    int          clog_n;

    always @(posedge clk) begin
        logic stb;
        stb = |phy_ctrl[19:16];
        if (!rst_n) begin
            hist <= '0; ack_r <= 1'b0; sdata <= '0; r_addr <= '0; r_data <= '0;
            last_ctrl <= '0; clog_n <= 0;
            for (int i = 0; i < 8; i++) mem[i] <= 16'h0101 * 16'(i) + 16'h0007;
        end else begin
            hist <= {hist[30:0], stb};
            if (mode == 1)      ack_r <= 1'b0;
            else if (mode == 2) ack_r <= 1'b1;
            else if (lat == 0)  ack_r <= stb;
            else                ack_r <= hist[lat-1];
            if (phy_ctrl[16]) r_addr <= phy_ctrl[2:0];
            if (phy_ctrl[17]) r_data <= phy_ctrl[15:0];
            if (phy_ctrl[18]) mem[r_addr] <= r_data;
            if (phy_ctrl[19]) sdata <= mem[r_addr];
            if (phy_ctrl != last_ctrl) begin
                last_ctrl <= phy_ctrl;
                if (clog_n < 4096) clog[clog_n] <= phy_ctrl;
                clog_n <= clog_n + 1;
            end
        end
    end
    assign phy_stat = {ack_r, sdata};

    // ---------------- bookkeeping ----------------
    int tests = 0;
    int fails = 0;
    logic [15:0] exp_mem [8];
    logic [19:0] exp_log [9];
    int          exp_n;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // run one command; inject_at > 0 presents a stray command while busy
    task automatic run_op(input bit wr, input logic [15:0] addr, input logic [15:0] data,
                          input int inject_at, output logic [15:0] rd,
                          output bit err, output int cyc, output int n0);
        @(negedge clk);
        n0 = clog_n;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_wdata = data;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            cmd_valid = 1'b0;
            if (inject_at > 0 && cyc >= inject_at && cyc < inject_at + 3 && !rsp_done) begin
                chk(cmd_ready == 1'b0, "R7 ready low while busy", cmd_ready, 0);
                cmd_valid = 1'b1; cmd_write = 1'b1;
                cmd_addr = 16'h0A45; cmd_wdata = 16'hDEAD;
            end
        end while (!rsp_done && cyc < 3000);
        cmd_valid = 1'b0;
        chk(rsp_done == 1'b1, "R8 done seen", rsp_done, 1);
        err = rsp_error;
        rd  = rsp_rdata;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R8 done one cycle", rsp_done, 0);
        chk(rsp_error == 1'b0, "R8 error cleared", rsp_error, 0);
        chk(phy_ctrl == 20'h0, "R6/R7 control parked after op", phy_ctrl, 0);
        chk(cmd_ready == 1'b1, "R7 ready after op", cmd_ready, 1);
    endtask

    task automatic cmp_log(input int n0, input string req);
        chk(clog_n - n0 == exp_n, {req, " control word change count"}, clog_n - n0, exp_n);
        for (int j = 0; j < exp_n; j++)
            chk(clog[n0 + j] == exp_log[j], {req, " control word step"}, clog[n0 + j], exp_log[j]);
    endtask

    function automatic int phase_len(input int l);
        int s;
        s = (l + GAP) / GAP;          // ceil((l+1)/GAP)
        return 1 + s * GAP;
    endfunction

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <150000", wd);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rd;
        bit          err;
        int          cyc, n0, w;
        int          lats [5] = '{0, 1, 2, 5, 17};
        logic [15:0] a, dv;

        for (int i = 0; i < 8; i++) exp_mem[i] = 16'h0101 * 16'(i) + 16'h0007;
        cyc_wait(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(phy_ctrl == 20'h0, "R10 ctrl zero", phy_ctrl, 0);
        chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
        chk(rsp_done == 1'b0, "R10 done low", rsp_done, 0);
        chk(rsp_error == 1'b0, "R10 error low", rsp_error, 0);
        chk(rsp_rdata == 16'h0, "R10 rdata zero", rsp_rdata, 0);

        // sweep latency x address: writes then reads
        foreach (lats[k]) begin
            lat = lats[k];
            cyc_wait(40);
            w = phase_len(lat);
            for (int i = 0; i < 8; i++) begin
                a  = 16'h0A40 + 16'(i);
                dv = 16'h5A01 ^ (16'h0111 * 16'(i)) ^ 16'(lat << 8);
                run_op(1'b1, a, dv, 0, rd, err, cyc, n0);
                exp_mem[i] = dv;
                chk(err == 1'b0, "R8 write no error", err, 0);
                chk(cyc == 3 + 6 * w, "R5 write duration", cyc, 3 + 6 * w);
                exp_log = '{20'(a), 20'(a) | 20'h10000, 20'(a), 20'(dv), 20'(dv) | 20'h20000,
                            20'(dv), 20'h40000, 20'(dv), 20'h0};
                exp_n = 9;
                cmp_log(n0, "R1 R2 R3 write");
            end
            for (int i = 0; i < 8; i++) begin
                a = 16'h0A40 + 16'(i);
                run_op(1'b0, a, 16'hFFFF, 0, rd, err, cyc, n0);
                chk(err == 1'b0, "R8 read no error", err, 0);
                chk(rd == exp_mem[i], "R4 read data", rd, exp_mem[i]);
                chk(cyc == 2 + 4 * w, "R5 read duration", cyc, 2 + 4 * w);
                exp_log[0] = 20'(a); exp_log[1] = 20'(a) | 20'h10000; exp_log[2] = 20'(a);
                exp_log[3] = 20'h80000; exp_log[4] = 20'h0;
                exp_n = 5;
                cmp_log(n0, "R1 R2 R4 read");
            end
        end

        // R9: acknowledge arriving on the last sample (lat 17, GAP 2) succeeds
        lat = 17;
        cyc_wait(40);
        run_op(1'b0, 16'h0A42, 16'h0, 0, rd, err, cyc, n0);
        chk(err == 1'b0, "R9 last-sample success", err, 0);
        chk(rd == exp_mem[2], "R9 data on last sample", rd, exp_mem[2]);

        // R6: one cycle later it times out in the first phase
        lat = 18;
        cyc_wait(40);
        rd = rsp_rdata;
        run_op(1'b1, 16'h0A43, 16'h7777, 0, dv, err, cyc, n0);
        chk(err == 1'b1, "R6 timeout past last sample", err, 1);
        chk(cyc == 3 + 9 * GAP, "R6 timeout timing", cyc, 3 + 9 * GAP);
        chk(rsp_rdata == rd, "R4 rdata kept on write timeout", rsp_rdata, rd);

        // R6: acknowledge stuck low
        lat = 0; mode = 1;
        cyc_wait(40);
        run_op(1'b0, 16'h0A44, 16'h0, 0, rd, err, cyc, n0);
        chk(err == 1'b1, "R6 stuck-low error", err, 1);
        chk(cyc == 3 + 9 * GAP, "R6 stuck-low timing", cyc, 3 + 9 * GAP);
        exp_log[0] = 20'h0A44; exp_log[1] = 20'h1_0A44; exp_log[2] = 20'h0; exp_n = 3;
        cmp_log(n0, "R6 stuck-low");

        // R6: acknowledge stuck high fails on the release of the address strobe
        mode = 2;
        cyc_wait(10);
        run_op(1'b0, 16'h0A41, 16'h0, 0, rd, err, cyc, n0);
        chk(err == 1'b1, "R6 stuck-high error", err, 1);
        chk(cyc == 4 + 9 * GAP, "R6 stuck-high timing", cyc, 4 + 9 * GAP);
        exp_log[0] = 20'h0A41; exp_log[1] = 20'h1_0A41; exp_log[2] = 20'h0A41;
        exp_log[3] = 20'h0; exp_n = 4;
        cmp_log(n0, "R6 stuck-high");

        // recovery after timeouts, including the data the timed-out write never stored
        mode = 0; lat = 2;
        cyc_wait(40);
        run_op(1'b0, 16'h0A43, 16'h0, 0, rd, err, cyc, n0);
        chk(err == 1'b0, "R6 recovery no error", err, 0);
        chk(rd == exp_mem[3], "R6 recovery data", rd, exp_mem[3]);

        // R7: a stray command while busy is ignored
        run_op(1'b1, 16'h0A42, 16'h3C3C, 5, rd, err, cyc, n0);
        exp_mem[2] = 16'h3C3C;
        chk(err == 1'b0, "R7 op with stray command", err, 0);
        chk(cyc == 3 + 6 * phase_len(2), "R7 op length unchanged", cyc, 3 + 6 * phase_len(2));
        run_op(1'b0, 16'h0A45, 16'h0, 0, rd, err, cyc, n0);
        chk(rd == exp_mem[5], "R7 stray write ignored", rd, exp_mem[5]);
        run_op(1'b0, 16'h0A42, 16'h0, 0, rd, err, cyc, n0);
        chk(rd == 16'h3C3C, "R3 write landed", rd, 16'h3C3C);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule